// File: doc/BRIEF.md
# Horizontal Sync Lock Monitor

This block checks whether detected horizontal sync pulses arrive where a free-running line timebase expects them. A line counter advances on each pixel-rate enable and wraps at a programmable line length. The predicted sync position is counter value 0. A detected sync is accepted only if it lands within a tolerance of that position, on either side. When a sync is accepted, the counter restarts from it. When no sync is accepted, the counter keeps running at the programmed length, so the line timing carries on without input sync.

Each line produces a fast per-line verdict on `valid`. A slower field-level verdict comes from counting unlocked lines between field boundary pulses. If too many lines in one field are unlocked, the active-low interrupt `int_n` asserts. It releases at the end of a field that stayed under the limit. `locked` repeats the inverse of the interrupt condition one cycle later, for status use.

Top module: `hsync_lock_monitor`

## Requirements
- R1: On each cycle with `pix_en` high, the line position advances by one and wraps from `line_len`-1 to 0 when no sync is accepted.
- R2: A sync is accepted only when `sync_det` and `pix_en` are both high and the position is at most WIN (16) or at least `line_len`-WIN. A sync at any other position has no effect.
- R3: An accepted sync sets `valid` high on the next cycle and re-centres the line, so the accepted cycle becomes position 0 and the next enabled cycle is position 1.
- R4: On the enabled cycle at position WIN, if no sync has been accepted since the previous such evaluation (and none is accepted in this cycle), `valid` goes low on the next cycle and one unlocked line is counted.
- R5: While `rst_n` is low, `valid`, `int_n` and `locked` are all 0.
- R6: The unlocked-line count saturates at THRESH (128) and clears on `field_pulse`. A miss in the same cycle as `field_pulse` is discarded and is not counted in the new field.
- R7: `int_n` falls on the cycle after the THRESH-th unlocked line of a field.
- R8: On `field_pulse`, `int_n` becomes 1 if the ending field had fewer than THRESH unlocked lines and 0 otherwise. The first `field_pulse` after reset only marks the start of a full field and leaves `int_n` at 0.
- R9: `locked` equals `int_n` delayed by one clock.
- R10: Cycles with `pix_en` low change neither the position nor `valid`, even when `sync_det` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate enable |
| sync_det | input | 1 | Detected horizontal sync pulse |
| line_len | input | CNT_W | Expected line length in pixels (greater than 2·WIN+1) |
| field_pulse | input | 1 | Field boundary pulse |
| valid | output | 1 | Per-line sync-in-window flag |
| int_n | output | 1 | Active-low too-many-unlocked-lines interrupt |
| locked | output | 1 | Lock status, `int_n` registered |

## Verification
The bench drives syncs on the exact window edges: positions `line_len`-16 and 16 must be accepted, and positions `line_len`-17 and 17 must be ignored. An off-by-one comparator would show up as `valid` disagreeing with the model. It counts unlocked lines to exactly 127 and 128 within a field. A threshold that is off by one would either release the interrupt when it should not or fail to drop it. It places a field pulse on the same cycle as a miss and then adds 127 more misses. A design that counted the coincident miss would drop `int_n`. It also checks that the first field pulse after reset does not raise `int_n`, and that a sync arriving while `pix_en` is low leaves everything unchanged.

// File: rtl/hsync_lock_monitor.sv
module hsync_lock_monitor #(
  parameter int CNT_W  = 11,
  parameter int WIN    = 16,
  parameter int THRESH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             sync_det,
  input  logic [CNT_W-1:0] line_len,
  input  logic             field_pulse,
  output logic             valid,
  output logic             int_n,
  output logic             locked
);
  localparam int UW = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [UW-1:0]    THR_C = UW'(THRESH);
  localparam logic [UW-1:0]    U1_C  = UW'(1);

  logic [CNT_W-1:0] cnt;
  logic [UW-1:0]    ulc;
  logic             hit, armed;

  wire in_win = (cnt <= WIN_C) || (cnt >= line_len - WIN_C);
  wire acc    = pix_en && sync_det && in_win;
  wire eval   = pix_en && (cnt == WIN_C);
  wire miss   = eval && !hit && !acc;
  wire wrap   = cnt >= line_len - ONE_C;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      hit   <= 1'b0;
      valid <= 1'b0;
    end else if (pix_en) begin
      cnt <= acc ? ONE_C : (wrap ? '0 : cnt + ONE_C);
      if (acc)       hit <= 1'b1;
      else if (eval) hit <= 1'b0;
      if (acc)       valid <= 1'b1;
      else if (miss) valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ulc    <= '0;
      armed  <= 1'b0;
      int_n  <= 1'b0;
      locked <= 1'b0;
    end else begin
      locked <= int_n;
      if (field_pulse) begin
        ulc   <= '0;
        armed <= 1'b1;
        if (armed) int_n <= (ulc < THR_C);
      end else if (miss && ulc < THR_C) begin
        ulc <= ulc + U1_C;
        if (ulc == THR_C - U1_C) int_n <= 1'b0;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(sync_det && pix_en)); // R3
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> $past(eval)); // R4
  AST_ULC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ulc <= THR_C); // R6
  AST_INT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(miss || field_pulse)); // R7
  AST_INT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(field_pulse && armed)); // R8
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(int_n)); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(cnt) && $stable(valid)); // R10
endmodule

// File: tb/tb_hsync_lock_monitor.sv
module tb_hsync_lock_monitor;
  localparam int L = 64;
  logic clk = 0, rst_n = 0, pix_en = 0, sync_det = 0, field_pulse = 0;
  logic [10:0] line_len = 11'(L);
  logic valid, int_n, locked;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  hsync_lock_monitor dut (.clk(clk), .rst_n(rst_n), .pix_en(pix_en), .sync_det(sync_det),
    .line_len(line_len), .field_pulse(field_pulse), .valid(valid), .int_n(int_n), .locked(locked));

  always #10 clk = ~clk;

  int m_pos, m_ulc, m_fmiss;
  bit m_hit, m_valid, m_int, m_lock, m_armed, m_a, m_ev, m_ms;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_ulc = 0; m_fmiss = 0; m_hit = 0; m_valid = 0;
      m_int = 0; m_lock = 0; m_armed = 0;
    end else begin
      m_lock = m_int;
      m_ms = 0;
      if (pix_en) begin
        m_a  = sync_det && (m_pos <= 16 || m_pos >= L - 16);
        m_ev = (m_pos == 16);
        m_ms = m_ev && !m_hit && !m_a;
        if (m_a) m_valid = 1; else if (m_ms) m_valid = 0;
        if (m_a) m_hit = 1; else if (m_ev) m_hit = 0;
        m_pos = m_a ? 1 : (m_pos + 1) % L;
      end
      if (field_pulse) begin
        if (m_armed) m_int = (m_ulc < 128);
        m_armed = 1; m_ulc = 0; m_fmiss = 0;
      end else if (m_ms) begin
        m_fmiss++;
        if (m_ulc < 128) m_ulc++;
        if (m_ulc == 128 && m_ms) m_int = (m_fmiss > 128) ? m_int : 0;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 valid vs model", valid, m_valid);
    chk("R7 int_n vs model", int_n, m_int);
    chk("R9 locked vs model", locked, m_lock);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic en, input logic s, input logic f);
    @(negedge clk); pix_en = en; sync_det = s; field_pulse = f;
  endtask

  task automatic sync_at(input int target);
    @(negedge clk);
    field_pulse = 0;
    while (m_pos != target) begin pix_en = 1; sync_det = 0; @(negedge clk); end
    pix_en = 1; sync_det = 1;
    @(negedge clk); sync_det = 0;
  endtask

  task automatic idle_until_fmiss(input int n);
    while (m_fmiss < n) step(1, 0, 0);
  endtask

  task automatic idle_until_miss;
    int start = m_fmiss;
    while (m_fmiss == start) step(1, 0, 0);
  endtask

  initial begin
    repeat (5) step(0, 0, 0);
    chk("R5 reset valid", valid, 0);
    chk("R5 reset int_n", int_n, 0);
    chk("R5 reset locked", locked, 0);
    @(negedge clk); rst_n = 1;

    step(1, 0, 1); step(1, 0, 0);
    chk("R8 first field pulse leaves int_n low", int_n, 0);

    for (int i = 0; i < 10; i++) sync_at(0);
    chk("R3 locked syncs give valid", valid, 1);
    step(1, 0, 1); step(1, 0, 0);
    chk("R8 clean field raises int_n", int_n, 1);
    step(1, 0, 0);
    chk("R9 locked follows int_n", locked, 1);

    idle_until_miss(); step(1, 0, 0);
    chk("R4 missing sync drops valid", valid, 0);
    sync_at(L - 16);
    chk("R2 sync at early edge accepted", valid, 1);
    idle_until_miss(); idle_until_miss(); step(1, 0, 0);
    chk("R3 recentred line then miss", valid, 0);
    sync_at(L - 17);
    chk("R2 sync before window ignored", valid, 0);
    sync_at(16);
    chk("R2 sync at late edge accepted", valid, 1);
    idle_until_miss(); idle_until_miss(); step(1, 0, 0);
    sync_at(17);
    chk("R2 sync after window ignored", valid, 0);

    repeat (50) step(0, 1, 0);
    chk("R10 disabled sync ignored", valid, 0);
    step(1, 0, 0);
    sync_at(0);
    chk("R1 position held while disabled", valid, 1);

    step(1, 0, 1); step(1, 0, 0);
    idle_until_fmiss(127); step(1, 0, 0);
    chk("R7 127 misses keep int_n high", int_n, 1);
    idle_until_fmiss(128); step(1, 0, 0);
    chk("R7 128th miss drops int_n", int_n, 0);
    step(1, 0, 1); step(1, 0, 0);
    chk("R8 bad field keeps int_n low", int_n, 0);
    idle_until_fmiss(127);
    step(1, 0, 1); step(1, 0, 0);
    chk("R6 field with 127 misses raises int_n", int_n, 1);

    @(negedge clk);
    while (m_pos != 16) begin pix_en = 1; sync_det = 0; field_pulse = 0; @(negedge clk); end
    pix_en = 1; field_pulse = 1;
    @(negedge clk); field_pulse = 0;
    idle_until_fmiss(127); step(1, 0, 0);
    chk("R6 coincident miss discarded", int_n, 1);
    step(1, 0, 1); step(1, 0, 0);
    chk("R6 int_n stays high after 127", int_n, 1);
    step(1, 0, 0);
    chk("R9 locked high", locked, 1);

    for (int i = 0; i < 20000; i++)
      step(($urandom % 4) != 0, ($urandom % 60) == 0, ($urandom % 3000) == 0);
    step(0, 0, 0); step(0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule